// File: doc/BRIEF.md
# Banked Status and Interrupt-Enable Register Block

This block is the register front end that a microcontroller sees over a small synchronous parallel bus. It presents one status register that combines live buffer-pointer flags with sticky event latches, a matching interrupt-enable register, a second enable register, and two control registers. A bank-select bit in control register 1 decides whether the two lowest addresses show the status registers or the interrupt-enable registers. Software therefore flips the bank to program the masks and flips it back to poll status.

The three low status bits follow an external write-pointer flag input cycle by cycle. The five upper bits are latches: a one-cycle condition strobe sets them, and a read of status register 1 returns their value and clears them. Flag transitions and strobes that are enabled produce an active-low interrupt pulse of a fixed length. The two low flags fire on either edge and the top flag fires only when it rises. If a request arrives while a pulse is in progress, it is kept and produces a second pulse after a single high cycle.

Top module: `stat_irq_bank`

## Requirements
- R1: After reset the control registers and both interrupt-enable registers are zero, address 0 shows status, and irq_n is high.
- R2: Bit 0 of control register 1 (address 2) selects the bank. When it is 0, address 0 reads status register 1 and address 1 reads a reserved status register that returns zero. When it is 1, address 0 is interrupt-enable register 1 and address 1 is interrupt-enable register 2, and both can be read and written.
- R3: Bits 2..0 of status register 1 equal the wptr_flags input in the cycle the read is sampled. They are not latched.
- R4: A high on evt_strobe[k] sets bit 3+k of status register 1. The bit stays set until status register 1 is read (address 0 with bank bit 0). That read returns the set bits and clears them all.
- R5: If evt_strobe[k] is high in the same cycle as the clearing read, bit 3+k is still set afterwards.
- R6: A change on wptr_flags[0] or wptr_flags[1] in either direction is an interrupt source. wptr_flags[2] is a source only when it rises.
- R7: Bit n of interrupt-enable register 1 gates the source behind status bit n. A source whose enable bit is 0 produces no pulse.
- R8: An interrupt is irq_n low for exactly 4 consecutive cycles. The pulse starts in the cycle after the clock edge that samples the request.
- R9: Any requests that arrive during a pulse produce exactly one more pulse. That pulse starts after irq_n has been high for one cycle.
- R10: An access is made when bus_cs_n is low. bus_we = 1 writes and bus_we = 0 reads. Read data appears on bus_rdata in the cycle after the read access, and bus_rdata is zero in every other cycle.
- R11: Addresses 4 to 31 read as zero and ignore writes. Writes to the status bank are ignored. Address 3 is control register 2, which can be read and written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wptr_flags | input | 3 | Buffer write-pointer flags |
| evt_strobe | input | 5 | Event condition strobes, one per sticky bit |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
A lost or corrupted sticky latch appears at the port on the next status read, one cycle after the access, as a wrong upper bit. A miscounted pulse or a wrongly held pending request shows on irq_n within five cycles of the request, as a pulse of the wrong width or a missing or extra pulse. A wrong edge detector or enable mask shows as a pulse where none is due, or as silence where a pulse is due, in the cycle after the flag change. A wrong bank bit shows on the very next read of address 0.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_LOW  = 2'd1,
    PS_GAP  = 2'd2
  } pulse_state_e;

  localparam int unsigned ADR_BANK_LO = 0;
  localparam int unsigned ADR_BANK_HI = 1;
  localparam int unsigned ADR_CTRL1   = 2;
  localparam int unsigned ADR_CTRL2   = 3;
  localparam int unsigned BANK_BIT    = 0;

endpackage

// File: rtl/stat_bus_regs.sv
module stat_bus_regs
  import stat_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sr1_val,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ien1,
  output logic              sr1_rd
);

  logic [DATA_W-1:0] ctrl1_q, ctrl1_d;
  logic [DATA_W-1:0] ctrl2_q, ctrl2_d;
  logic [DATA_W-1:0] ien1_q, ien1_d;
  logic [DATA_W-1:0] ien2_q, ien2_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] rmux;
  logic rd_acc, wr_acc, bank;
  logic hit_lo, hit_hi, hit_c1, hit_c2;

  always_comb begin
    rd_acc = !cs_n && !we;
    wr_acc = !cs_n && we;
    hit_lo = (addr == ADDR_W'(ADR_BANK_LO));
    hit_hi = (addr == ADDR_W'(ADR_BANK_HI));
    hit_c1 = (addr == ADDR_W'(ADR_CTRL1));
    hit_c2 = (addr == ADDR_W'(ADR_CTRL2));
    bank   = ctrl1_q[BANK_BIT];
    sr1_rd = rd_acc && hit_lo && !bank;
  end

  // next-state for the writable registers
  always_comb begin
    ctrl1_d = ctrl1_q;
    ctrl2_d = ctrl2_q;
    ien1_d  = ien1_q;
    ien2_d  = ien2_q;
    if (wr_acc) begin
      if (hit_c1)          ctrl1_d = wdata;
      if (hit_c2)          ctrl2_d = wdata;
      if (hit_lo && bank)  ien1_d  = wdata;
      if (hit_hi && bank)  ien2_d  = wdata;
    end
  end

  // read multiplexer
  always_comb begin
    rmux = '0;
    if (hit_lo)      rmux = bank ? ien1_q : sr1_val;
    else if (hit_hi) rmux = bank ? ien2_q : '0;
    else if (hit_c1) rmux = ctrl1_q;
    else if (hit_c2) rmux = ctrl2_q;
    rdata_d = rd_acc ? rmux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= '0;
      ien1_q  <= '0;
      ien2_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl1_q <= ctrl1_d;
      ctrl2_q <= ctrl2_d;
      ien1_q  <= ien1_d;
      ien2_q  <= ien2_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign ien1  = ien1_q;

endmodule

// File: rtl/stat_event_unit.sv
module stat_event_unit #(
  parameter int unsigned          N_FLAGS   = 3,
  parameter int unsigned          N_LATCH   = 5,
  parameter logic [N_FLAGS-1:0]   BOTH_EDGE = 3'b011,
  localparam int unsigned         N_SRC     = N_FLAGS + N_LATCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] flags,
  input  logic [N_LATCH-1:0] evt,
  input  logic               clr,
  input  logic [N_SRC-1:0]   ien,
  output logic [N_LATCH-1:0] sticky,
  output logic               irq_req
);

  logic [N_FLAGS-1:0] prev_q, prev_d;
  logic [N_LATCH-1:0] sticky_q, sticky_d;
  logic [N_FLAGS-1:0] flag_ev;

  // edge selection per flag
  for (genvar i = 0; i < N_FLAGS; i++) begin : g_edge
    if (BOTH_EDGE[i]) begin : g_both
      assign flag_ev[i] = flags[i] ^ prev_q[i];
    end else begin : g_rise
      assign flag_ev[i] = flags[i] & ~prev_q[i];
    end
  end

  always_comb begin
    prev_d   = flags;
    // a strobe wins over a clear in the same cycle
    sticky_d = (sticky_q & {N_LATCH{~clr}}) | evt;
    irq_req  = |({evt, flag_ev} & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      sticky_q <= '0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign sticky = sticky_q;

endmodule

// File: rtl/stat_irq_pulse.sv
module stat_irq_pulse
  import stat_irq_pkg::*;
#(
  parameter int unsigned  PULSE_CYC = 4,
  localparam int unsigned CNT_W     = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic irq_n,
  output logic pend
);

  pulse_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    unique case (state_q)
      PS_IDLE, PS_GAP: begin
        if (req || pend_q) begin
          state_d = PS_LOW;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end else begin
          state_d = PS_IDLE;
        end
      end
      PS_LOW: begin
        if (req) pend_d = 1'b1;
        if (cnt_q == CNT_W'(PULSE_CYC - 1)) state_d = PS_GAP;
        else                                cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
    end
  end

  assign irq_n = (state_q != PS_LOW);
  assign pend  = pend_q;

endmodule

// File: rtl/stat_irq_bank.sv
module stat_irq_bank #(
  parameter int unsigned  ADDR_W    = 5,
  parameter int unsigned  N_FLAGS   = 3,
  parameter int unsigned  N_LATCH   = 5,
  parameter int unsigned  PULSE_CYC = 4,
  localparam int unsigned DATA_W    = N_FLAGS + N_LATCH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_cs_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [N_FLAGS-1:0] wptr_flags,
  input  logic [N_LATCH-1:0] evt_strobe,
  output logic               irq_n
);

  logic rst_meta_q, rst_sync_n;
  logic [DATA_W-1:0]  ien1;
  logic [N_LATCH-1:0] sticky;
  logic [DATA_W-1:0]  sr1_val;
  logic sr1_rd, irq_req, pulse_pend;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign sr1_val = {sticky, wptr_flags};

  stat_bus_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cs_n    (bus_cs_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .sr1_val (sr1_val),
    .rdata   (bus_rdata),
    .ien1    (ien1),
    .sr1_rd  (sr1_rd)
  );

  stat_event_unit #(
    .N_FLAGS (N_FLAGS),
    .N_LATCH (N_LATCH)
  ) u_events (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flags   (wptr_flags),
    .evt     (evt_strobe),
    .clr     (sr1_rd),
    .ien     (ien1),
    .sticky  (sticky),
    .irq_req (irq_req)
  );

  stat_irq_pulse #(
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req   (irq_req),
    .irq_n (irq_n),
    .pend  (pulse_pend)
  );

endmodule

// File: rtl/stat_irq_bank_chk.sv
module stat_irq_bank_chk #(
  parameter int unsigned N_LATCH   = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_CYC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               we,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_n,
  input logic               irq_req,
  input logic               pend,
  input logic               sr1_rd,
  input logic [N_LATCH-1:0] evt,
  input logic [N_LATCH-1:0] sticky
);

  localparam int unsigned RUN_W = $clog2(PULSE_CYC + 2) + 1;

  logic armed;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_run <= '0;
    end else begin
      armed   <= 1'b1;
      low_run <= irq_n ? '0 : low_run + 1'b1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && low_run != 0) |-> (low_run == RUN_W'(PULSE_CYC))); // R8

  AST_PULSE_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_W'(PULSE_CYC)); // R8

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(irq_n)) |-> $past(irq_req || pend)); // R9

  AST_LATCH_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (($past(sticky) & ~sticky) != '0)) |-> $past(sr1_rd)); // R4

  AST_STROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((sticky & $past(evt)) == $past(evt))); // R5

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cs_n || we)) |-> (rdata == '0)); // R10

endmodule

bind stat_irq_bank stat_irq_bank_chk #(
  .N_LATCH   (N_LATCH),
  .DATA_W    (DATA_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs_n    (bus_cs_n),
  .we      (bus_we),
  .rdata   (bus_rdata),
  .irq_n   (irq_n),
  .irq_req (irq_req),
  .pend    (pulse_pend),
  .sr1_rd  (sr1_rd),
  .evt     (evt_strobe),
  .sticky  (sticky)
);

// File: tb/test_stat_irq_bank.sv
module test_stat_irq_bank;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, we;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;
  logic [2:0] flags;
  logic [4:0] evt;
  logic       irq_n;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  stat_irq_bank i_stat_irq_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (cs_n),
    .bus_we     (we),
    .bus_addr   (addr),
    .bus_wdata  (wdata),
    .bus_rdata  (rdata),
    .wptr_flags (flags),
    .evt_strobe (evt),
    .irq_n      (irq_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; we = 1'b0; addr = a;
    @(negedge clk);
    cs_n = 1'b1;
    d = rdata;
  endtask

  task automatic set_bank(input logic b);
    bus_write(5'd2, {7'd0, b});
  endtask

  task automatic set_ien1(input logic [7:0] v);
    set_bank(1'b1);
    bus_write(5'd0, v);
    set_bank(1'b0);
  endtask

  // called at the negedge right after the sampling edge
  task automatic expect_pulse(input string tag);
    for (int k = 0; k < 4; k++) begin
      check(tag, irq_n, 1'b0);
      @(negedge clk);
    end
    check(tag, irq_n, 1'b1);
  endtask

  task automatic expect_quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      check(tag, irq_n, 1'b1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq_n after reset", irq_n, 1'b1);
    bus_read(5'd2, d); check("R1 ctrl1 reset", d, 8'h00);
    bus_read(5'd0, d); check("R1 status visible", d, 8'h00);
    set_bank(1'b1);
    bus_read(5'd0, d); check("R1 ien1 reset", d, 8'h00);
    bus_read(5'd1, d); check("R1 ien2 reset", d, 8'h00);
    set_bank(1'b0);
  endtask

  task automatic t_bank;
    logic [7:0] d;
    set_bank(1'b1);
    bus_write(5'd0, 8'h00);
    bus_write(5'd1, 8'h3C);
    bus_read(5'd1, d); check("R2 ien2 readback", d, 8'h3C);
    bus_write(5'd0, 8'hA0);
    bus_read(5'd0, d); check("R2 ien1 readback", d, 8'hA0);
    bus_write(5'd0, 8'h00);
    set_bank(1'b0);
    flags = 3'b101;
    bus_read(5'd0, d); check("R2 bank0 shows status", d, 8'h05);
    bus_read(5'd1, d); check("R2 reserved status zero", d, 8'h00);
  endtask

  task automatic t_flags_live;
    logic [7:0] d;
    flags = 3'b110;
    bus_read(5'd0, d); check("R3 live flags 110", d, 8'h06);
    flags = 3'b001;
    bus_read(5'd0, d); check("R3 live flags 001", d, 8'h01);
    flags = 3'b000;
    bus_read(5'd0, d); check("R3 live flags 000", d, 8'h00);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    @(negedge clk); evt = 5'b00101;
    @(negedge clk); evt = 5'b00000;
    repeat (3) @(negedge clk);
    bus_read(5'd0, d); check("R4 sticky held", d, 8'h28);
    bus_read(5'd0, d); check("R4 cleared by read", d, 8'h00);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    @(negedge clk); evt = 5'b00010;
    @(negedge clk); evt = 5'b00000;
    // clearing read with a new strobe in the same cycle
    cs_n = 1'b0; we = 1'b0; addr = 5'd0; evt = 5'b01000;
    @(negedge clk);
    cs_n = 1'b1; evt = 5'b00000;
    check("R4 read returns pre-clear", rdata, 8'h10);
    bus_read(5'd0, d); check("R5 coincident strobe kept", d, 8'h40);
    bus_read(5'd0, d); check("R5 then cleared", d, 8'h00);
  endtask

  task automatic t_flag_edges;
    flags = 3'b000;
    repeat (2) @(negedge clk);
    set_ien1(8'h07);
    @(negedge clk); flags = 3'b001; @(negedge clk); expect_pulse("R6 flag0 rise");
    @(negedge clk); flags = 3'b000; @(negedge clk); expect_pulse("R6 flag0 fall");
    @(negedge clk); flags = 3'b010; @(negedge clk); expect_pulse("R6 flag1 rise");
    @(negedge clk); flags = 3'b000; @(negedge clk); expect_pulse("R6 flag1 fall");
    @(negedge clk); flags = 3'b100; @(negedge clk); expect_pulse("R6 flag2 rise");
    @(negedge clk); flags = 3'b000; @(negedge clk); expect_quiet("R6 flag2 fall silent", 6);
    set_ien1(8'h00);
  endtask

  task automatic t_enable_gate;
    logic [7:0] d;
    set_ien1(8'h08);
    @(negedge clk); evt = 5'b00010; @(negedge clk); evt = 5'b0;
    expect_quiet("R7 disabled strobe", 6);
    @(negedge clk); flags = 3'b001; @(negedge clk);
    expect_quiet("R7 disabled flag", 6);
    @(negedge clk); evt = 5'b00001; @(negedge clk); evt = 5'b0;
    expect_pulse("R7 R8 enabled strobe");
    bus_read(5'd0, d); check("R7 latch set even when disabled", d, 8'h19);
    flags = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pending;
    logic [7:0] d;
    @(negedge clk); evt = 5'b00001;
    @(negedge clk); evt = 5'b0;
    check("R8 first low", irq_n, 1'b0);
    @(negedge clk); evt = 5'b00001;
    check("R8 second low", irq_n, 1'b0);
    @(negedge clk); evt = 5'b00001;
    check("R8 third low", irq_n, 1'b0);
    @(negedge clk); evt = 5'b0;
    check("R8 fourth low", irq_n, 1'b0);
    @(negedge clk);
    check("R9 one high gap", irq_n, 1'b1);
    @(negedge clk);
    expect_pulse("R9 pending pulse");
    @(negedge clk);
    expect_quiet("R9 requests collapsed", 4);
    bus_read(5'd0, d);
    set_ien1(8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    bus_write(5'd3, 8'h5A);
    bus_read(5'd3, d); check("R11 ctrl2 readback", d, 8'h5A);
    bus_write(5'd9, 8'hFF);
    bus_read(5'd9, d); check("R11 unmapped reads zero", d, 8'h00);
    bus_read(5'd31, d); check("R11 top address zero", d, 8'h00);
    bus_read(5'd3, d); check("R11 write to unmapped ignored", d, 8'h5A);
    bus_write(5'd0, 8'hFF);
    set_bank(1'b1);
    bus_read(5'd0, d); check("R11 status-bank write ignored", d, 8'h00);
    bus_read(5'd2, d); check("R2 ctrl1 holds bank bit", d, 8'h01);
    set_bank(1'b0);
    @(negedge clk);
    check("R10 rdata zero when idle", rdata, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    flags = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bank();
    t_flags_live();
    t_latch();
    t_collision();
    t_flag_edges();
    t_enable_gate();
    t_pending();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule